// File: doc/BRIEF.md
# Shared Interrupt Cause Register with Cross-Side Doorbells

This block holds the 32-bit interrupt cause word shared by two bus masters, a local CPU side and a PCI side. Single-cycle event pulses arrive from decode checks, DMA channels, timers, parity checkers and bus abort logic. Each pulse latches into its own sticky cause bit. Either master clears an event bit by writing a 0 to that bit position. A 1 in that position leaves the bit as it is.

Two doorbell fields let each side interrupt the other. A master rings a doorbell by writing 0 to it, and only the opposite master can clear that doorbell, also by writing 0. Bit 0 is a summary of the whole word and ignores both masks. Each side also has a mask input, and the block drives one masked interrupt line toward each side. Writes take effect at the clock edge on which they are presented. The summary bit and both interrupt lines follow the register contents and the mask inputs combinationally.

Top module: `irq_cause_reg`

## Requirements
- R1: After reset, every bit of `cause` is 0 and both `cpu_irq` and `pci_irq` are 0.
- R2: A 1 on `evt_pulse[k]` at a clock edge sets `cause[k+1]`. The bit order of `cause` is:
  - bit 1: device range miss or burst to a narrow device
  - bit 2: DMA range miss
  - bit 3: CPU decode miss
  - bits 4–7: DMA channels 0–3 done
  - bits 8–11: timers 0–3 expired
  - bits 12–15: master-read, slave-write, master-write and slave-read parity errors
  - bit 16: address parity error
  - bit 17: memory parity error
  - bit 18: master abort
  - bit 19: target abort
  - bit 20: retry limit reached
- R3: Event bits 20:1 stay set until a CPU-side or PCI-side write carries a 0 in that position. Writing 1 to an event bit leaves it unchanged.
- R4: When an event pulse and a clearing write hit the same event bit at the same edge, the bit ends up set.
- R5: Bits 25:21 form the CPU-to-PCI doorbell. A CPU-side write of 0 to one of these bits sets it. A PCI-side write of 0 clears it. A CPU-side write never clears it, and a PCI-side write never sets it.
- R6: Bits 29:26 form the PCI-to-CPU doorbell. A PCI-side write of 0 to one of these bits sets it. A CPU-side write of 0 clears it. A PCI-side write never clears it, and a CPU-side write never sets it.
- R7: When both sides write at the same edge, the CPU-side write is applied first and the PCI-side write second. As a result, a 0 from both sides leaves a CPU-to-PCI doorbell bit clear and a PCI-to-CPU doorbell bit set.
- R8: `cause[0]` is 1 exactly when any of `cause[29:1]` is 1, whatever the masks hold. Writes to bit 0 have no effect.
- R9: `cpu_irq` is 1 when any bit in 20:1 or 29:26 is set in both `cause` and `cpu_mask`.
- R10: `pci_irq` is 1 when any bit in 25:21 is set in both `cause` and `pci_mask`. Other bits do not affect it.
- R11: `cause[31:30]` always reads 0, and writes to those bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 20 | One-cycle event pulses; bit k feeds cause bit k+1 |
| cpu_we | input | 1 | CPU-side write strobe for the cause word |
| cpu_wdata | input | 32 | CPU-side write data |
| pci_we | input | 1 | PCI-side write strobe for the cause word |
| pci_wdata | input | 32 | PCI-side write data |
| cpu_mask | input | 32 | Enables for the CPU interrupt line |
| pci_mask | input | 32 | Enables for the PCI interrupt line |
| cause | output | 32 | Current cause word, summary bit included |
| cpu_irq | output | 1 | Masked interrupt toward the CPU side |
| pci_irq | output | 1 | Masked interrupt toward the PCI side |

## Verification
Writes and event pulses pass through one register stage. Their effect on `cause` is therefore due at the first rising edge after they are driven. The bench drives inputs on a falling edge, removes them on the next falling edge, and compares `cause` at that point. The summary bit and both interrupt lines depend only on the register and the masks, with no further delay. Mask changes are therefore checked a short settle time after being applied, with no clock edge in between.

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int EVT_W = 20,
  parameter int C2P_W = 5,
  parameter int P2C_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_pulse,
  input  logic             cpu_we,
  input  logic [31:0]      cpu_wdata,
  input  logic             pci_we,
  input  logic [31:0]      pci_wdata,
  input  logic [31:0]      cpu_mask,
  input  logic [31:0]      pci_mask,
  output logic [31:0]      cause,
  output logic             cpu_irq,
  output logic             pci_irq
);
  localparam int C2P_LO = EVT_W + 1;
  localparam int P2C_LO = C2P_LO + C2P_W;
  localparam int PAD_W  = 32 - EVT_W - 1;

  localparam logic [31:0] EV_M  = ((32'd1 << EVT_W) - 32'd1) << 1;
  localparam logic [31:0] C2P_M = ((32'd1 << C2P_W) - 32'd1) << C2P_LO;
  localparam logic [31:0] P2C_M = ((32'd1 << P2C_W) - 32'd1) << P2C_LO;
  localparam logic [31:0] KEEP  = EV_M | C2P_M | P2C_M;

  logic [31:0] q, after_cpu, after_pci, nxt;

  always_comb begin
    after_cpu = q;
    if (cpu_we)
      after_cpu = (q & (cpu_wdata | ~(EV_M | P2C_M))) | (~cpu_wdata & C2P_M);
    after_pci = after_cpu;
    if (pci_we)
      after_pci = (after_cpu & (pci_wdata | ~(EV_M | C2P_M))) | (~pci_wdata & P2C_M);
    nxt = (after_pci | {{PAD_W{1'b0}}, evt_pulse, 1'b0}) & KEEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assign cause   = {q[31:1], |q};
  assign cpu_irq = |(q & cpu_mask & (EV_M | P2C_M));
  assign pci_irq = |(q & pci_mask & C2P_M);
endmodule

// File: rtl/irq_cause_reg_chk.sv
module irq_cause_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [19:0] evt_pulse,
  input logic        cpu_we,
  input logic        pci_we,
  input logic [31:0] cause,
  input logic        pci_irq
);
  assert_evt_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != 20'd0) |=> ((cause[20:1] & $past(evt_pulse)) == $past(evt_pulse)));

  assert_evt_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_we && !pci_we) |=> ((cause[20:1] & $past(cause[20:1])) == $past(cause[20:1])));

  assert_c2p_set_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_we |=> ((cause[25:21] & ~$past(cause[25:21])) == 5'd0));

  assert_p2c_set_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pci_we |=> ((cause[29:26] & ~$past(cause[29:26])) == 4'd0));

  assert_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cause[0] == (cause[29:1] != 29'd0));

  assert_pci_irq_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pci_irq |-> (cause[25:21] != 5'd0));

  assert_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cause[31:30] == 2'b00);
endmodule

bind irq_cause_reg irq_cause_reg_chk chk_i (
  .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .cpu_we(cpu_we),
  .pci_we(pci_we), .cause(cause), .pci_irq(pci_irq)
);

// File: tb/irq_cause_reg_tb_top.sv
module irq_cause_reg_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] evt_pulse = '0;
  logic        cpu_we = 1'b0, pci_we = 1'b0;
  logic [31:0] cpu_wdata = '1, pci_wdata = '1;
  logic [31:0] cpu_mask = '0, pci_mask = '0;
  logic [31:0] cause;
  logic        cpu_irq, pci_irq;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cause_reg dut_i (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
    .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .pci_we(pci_we), .pci_wdata(pci_wdata),
    .cpu_mask(cpu_mask), .pci_mask(pci_mask),
    .cause(cause), .cpu_irq(cpu_irq), .pci_irq(pci_irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cycle(input logic cw, input logic [31:0] cd,
                       input logic pw, input logic [31:0] pd,
                       input logic [19:0] ev);
    cpu_we = cw; cpu_wdata = cd; pci_we = pw; pci_wdata = pd; evt_pulse = ev;
    @(negedge clk);
    cpu_we = 1'b0; pci_we = 1'b0; cpu_wdata = '1; pci_wdata = '1; evt_pulse = '0;
  endtask

  task automatic t_reset;
    chk("R1 cause", cause, 32'h0);
    chk("R1 cpu_irq", {31'b0, cpu_irq}, 32'h0);
    chk("R1 pci_irq", {31'b0, pci_irq}, 32'h0);
  endtask

  task automatic t_events;
    cycle(0, '1, 0, '1, 20'h00001);
    chk("R2 bit1 and R8 summary", cause, 32'h0000_0003);
    cycle(0, '1, 0, '1, 20'h80200);
    chk("R2 bits 10 and 20", cause, 32'h0010_0403);
    repeat (2) @(negedge clk);
    chk("R3 sticky", cause, 32'h0010_0403);
  endtask

  task automatic t_clear;
    cycle(1, ~32'h2, 0, '1, '0);
    chk("R3 cpu clears bit1", cause, 32'h0010_0401);
    cycle(0, '1, 1, ~32'h0010_0000, '0);
    chk("R3 pci clears bit20", cause, 32'h0000_0401);
    cycle(1, '1, 1, '1, '0);
    chk("R3 ones no effect", cause, 32'h0000_0401);
    cycle(1, ~32'h1, 0, '1, '0);
    chk("R8 bit0 write no effect", cause, 32'h0000_0401);
  endtask

  task automatic t_collide;
    cycle(1, ~32'h400, 0, '1, 20'h00200);
    chk("R4 event beats cpu clear", cause, 32'h0000_0401);
    cycle(0, '1, 1, ~32'h400, 20'h00200);
    chk("R4 event beats pci clear", cause, 32'h0000_0401);
    cycle(0, '1, 1, ~32'h400, '0);
    chk("R3 cleared", cause, 32'h0);
  endtask

  task automatic t_c2p;
    cycle(1, ~32'h0020_0000, 0, '1, '0);
    chk("R5 cpu sets bit21", cause, 32'h0020_0001);
    cycle(1, ~32'h0020_0000, 0, '1, '0);
    chk("R5 cpu cannot clear", cause, 32'h0020_0001);
    cycle(0, '1, 1, ~32'h0040_0000, '0);
    chk("R5 pci cannot set", cause, 32'h0020_0001);
    cycle(0, '1, 1, ~32'h0020_0000, '0);
    chk("R5 pci clears", cause, 32'h0);
  endtask

  task automatic t_p2c;
    cycle(0, '1, 1, ~32'h0800_0000, '0);
    chk("R6 pci sets bit27", cause, 32'h0800_0001);
    cycle(0, '1, 1, ~32'h0800_0000, '0);
    chk("R6 pci cannot clear", cause, 32'h0800_0001);
    cycle(1, ~32'h0400_0000, 0, '1, '0);
    chk("R6 cpu cannot set", cause, 32'h0800_0001);
    cycle(1, ~32'h0800_0000, 0, '1, '0);
    chk("R6 cpu clears", cause, 32'h0);
  endtask

  task automatic t_both;
    cycle(1, ~32'h0040_0000, 1, ~32'h0040_0000, '0);
    chk("R7 c2p cpu then pci", cause, 32'h0);
    cycle(1, ~32'h1000_0000, 1, ~32'h1000_0000, '0);
    chk("R7 p2c cpu then pci", cause, 32'h1000_0001);
    cycle(1, ~32'h1000_0000, 0, '1, '0);
    chk("R7 cleanup", cause, 32'h0);
  endtask

  task automatic t_reserved;
    cycle(1, 32'h0, 0, '1, '0);
    chk("R11 cpu all zero", cause, 32'h03E0_0001);
    cycle(0, '1, 1, 32'h0, '0);
    chk("R11 pci all zero", cause, 32'h3C00_0001);
    cycle(1, 32'h0, 0, '1, '0);
    chk("R11 cpu all zero again", cause, 32'h03E0_0001);
    cycle(0, '1, 1, ~32'h03E0_0000, '0);
    chk("R5 pci clears field", cause, 32'h0);
  endtask

  task automatic t_irq;
    cycle(0, '1, 0, '1, 20'h00008);
    cpu_mask = 32'h0; pci_mask = 32'hFFFF_FFFF; #1;
    chk("R8 summary ignores mask", {31'b0, cause[0]}, 32'h1);
    chk("R9 masked off", {31'b0, cpu_irq}, 32'h0);
    chk("R10 event not routed", {31'b0, pci_irq}, 32'h0);
    cpu_mask = 32'h10; #1;
    chk("R9 event enabled", {31'b0, cpu_irq}, 32'h1);
    cycle(0, '1, 1, ~32'h0400_0000, '0);
    cpu_mask = 32'h0400_0000; #1;
    chk("R9 doorbell enabled", {31'b0, cpu_irq}, 32'h1);
    cycle(1, ~32'h0080_0000, 0, '1, '0);
    chk("R5 cause after ring", cause, 32'h0480_0011);
    pci_mask = 32'h0080_0000; cpu_mask = 32'h0080_0000; #1;
    chk("R10 doorbell enabled", {31'b0, pci_irq}, 32'h1);
    chk("R9 c2p not routed", {31'b0, cpu_irq}, 32'h0);
    pci_mask = 32'h0; #1;
    chk("R10 masked off", {31'b0, pci_irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_events();
    t_clear();
    t_collide();
    t_c2p();
    t_p2c();
    t_both();
    t_reserved();
    t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule